// File: doc/BRIEF.md
# Calendar Clock with Register Port

This block keeps wall-clock time and a calendar in a small byte-wide register file. Seven time bytes (seconds, minutes, hours, weekday, day of month, month, two-digit year) sit at the lowest addresses. Four control and status registers follow them. A one-pulse-per-second input advances the time while the oscillator divider is running. A fixed-rate tick input drives a periodic interrupt flag.

Software sets the clock by writing the time bytes directly. Each write takes effect at once as the running time. A mode bit selects whether fields are held as packed BCD or as plain binary. Every carry through the calendar is written back in the mode that is currently selected. A set-inhibit bit freezes the time so that software can update it safely. Stopping the divider halts timekeeping. Restarting the divider delays the first second by half a second, which is measured in periodic ticks.

The register port is a plain synchronous strobe port. It never stalls, so there is no back-pressure: a write lands on the clock edge where `wr_en` is high, and read data appears on `rdata` one cycle after `rd_en`.

Top module: `rtc_core`

## Requirements
- R1: After reset, the time bytes read 00,00,00,07,01,01,00 (seconds through year, i.e. Saturday 2000-01-01 00:00:00). Register B (address 8) reads 0x42, register C (address 9) reads 0x00, and `irq` is low.
- R2: A write to address 0..6 (0=sec, 1=min, 2=hour, 3=weekday, 4=day, 5=month, 6=year) replaces that byte, and the running time continues from it. A read returns the addressed byte on `rdata` in the cycle after `rd_en`.
- R3: With register B bit 2 (binary mode) at 0, a seconds pulse counts in packed BCD, with tens in bits 7:4: 0x09 becomes 0x10, and 0x59 becomes 0x00 with a carry into minutes.
- R4: With register B bit 2 at 1, fields count in plain binary: 9 becomes 0x0A, and 59 becomes 0 with a carry into minutes.
- R5: Carries chain as follows: hour 23 to 0, weekday 7 to 1 (1 = Sunday), day of month past the month's length to 1, month 12 to 1, and year 99 to 00.
- R6: A two-digit year maps to 1950..2049. February has 29 days in leap years of that window (for example 00 = 2000) and 28 days otherwise.
- R7: Register A (address 7) bits 6:4 select the divider. Codes 110 and 111 stop it, and while it is stopped seconds pulses are ignored. Code 010 is the normal reset code.
- R8: When the divider code changes from a stopped code to a running code, seconds pulses are ignored. The first advance happens on the PER_HZ/2-th periodic tick counted from the second cycle after the write. After that, each seconds pulse advances the time.
- R9: While register B bit 7 (set inhibit) is 1, seconds pulses do not change the time.
- R10: Register A bit 7 (update flag) ignores writes. Every read of A toggles it first and returns the toggled value, so the first read after reset returns 0xA6.
- R11: Each periodic tick sets register C bit 6. Reading C returns {irq, flag, 6'b0} and clears the flag, unless a periodic tick arrives in the same cycle. `irq` is the flag ANDed with register B bit 6 (periodic enable).
- R12: Writes to registers C and D (addresses 9, 10) and to addresses 11..15 are ignored. D reads 0x80, and addresses 11..15 read 0x00.
- R13: Writes to A store bits 6:0, and writes to B store all eight bits. Both read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| pps | input | 1 | One-cycle pulse once per second |
| per_tick | input | 1 | One-cycle pulse at PER_HZ |
| irq | output | 1 | Periodic interrupt request |

## Verification
The assertions take `pps` and `per_tick` to be single-cycle pulses. They also take `rd_en` and `wr_en` to be used one at a time, so that a read of register A is never merged with a write to it. The hold checks on the time bytes are conditioned on `wr_en` being low, because a register write may legally change those bytes in any cycle. The stimulus drives every strobe for exactly one cycle from the falling edge, never overlaps a read with a write, and writes only legal field values in the active encoding.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADR_SEC  = 0;
  localparam int ADR_MIN  = 1;
  localparam int ADR_HOUR = 2;
  localparam int ADR_WDAY = 3;
  localparam int ADR_MDAY = 4;
  localparam int ADR_MON  = 5;
  localparam int ADR_YEAR = 6;
  localparam int ADR_A    = 7;
  localparam int ADR_B    = 8;
  localparam int ADR_C    = 9;
  localparam int ADR_D    = 10;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] mday;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  // packed BCD byte to binary value
  function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
    return 7'(b[7:4] * 4'd10 + b[3:0]);
  endfunction

  // binary value (0..99) to packed BCD byte
  function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return {tens, ones};
  endfunction

endpackage

// File: rtl/rtc_secgen.sv
module rtc_secgen #(
  parameter int PER_HZ = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pps,
  input  logic per_tick,
  output logic sec_tick
);
  localparam int HALF  = PER_HZ / 2;
  localparam int CNT_W = $clog2(HALF + 1);

  logic             run_q;
  logic             wait_q;
  logic [CNT_W-1:0] cnt_q;
  logic             half_done;

  assign half_done = per_tick && (cnt_q == CNT_W'(HALF - 1));
  assign sec_tick  = run && (wait_q ? half_done : (pps && run_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      wait_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      run_q <= run;
      if (!run) begin
        wait_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!run_q) begin
        wait_q <= 1'b1;
        cnt_q  <= '0;
      end else if (wait_q && per_tick) begin
        if (half_done) wait_q <= 1'b0;
        else           cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R8: no seconds advance while waiting for the half-second delay without a periodic tick
  assert_half_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !per_tick) |-> !sec_tick);

  // R7: a stopped divider lets no pulse through in the next cycle either
  assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pps) |=> (!sec_tick || wait_q || run_q));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      bin_mode,
  output rtc_time_t nxt
);
  logic [6:0] d_sec, d_min, d_hour, d_wday, d_mday, d_mon, d_year;
  logic       c_min, c_hour, c_day, c_mon, c_year;
  logic [6:0] dim;

  function automatic logic [6:0] dec(input logic [7:0] raw, input logic bm);
    return bm ? raw[6:0] : bcd_to_bin(raw);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bm);
    return bm ? {1'b0, v} : bin_to_bcd(v);
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] m, input logic [6:0] y);
    int  full;
    logic leap;
    full = (y < 7'd50) ? 2000 + int'(y) : 1900 + int'(y);
    leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    case (m)
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      7'd2:                    return leap ? 7'd29 : 7'd28;
      default:                 return 7'd31;
    endcase
  endfunction

  always_comb begin
    d_sec  = dec(cur.sec,  bin_mode);
    d_min  = dec(cur.min,  bin_mode);
    d_hour = dec(cur.hour, bin_mode);
    d_wday = dec(cur.wday, bin_mode);
    d_mday = dec(cur.mday, bin_mode);
    d_mon  = dec(cur.mon,  bin_mode);
    d_year = dec(cur.year, bin_mode);
    dim    = month_len(d_mon, d_year);

    c_min  = d_sec >= 7'd59;
    c_hour = c_min  && (d_min  >= 7'd59);
    c_day  = c_hour && (d_hour >= 7'd23);
    c_mon  = c_day  && (d_mday >= dim);
    c_year = c_mon  && (d_mon  >= 7'd12);

    nxt      = cur;
    nxt.sec  = enc(c_min ? 7'd0 : d_sec + 7'd1, bin_mode);
    if (c_min)  nxt.min  = enc(c_hour ? 7'd0 : d_min + 7'd1, bin_mode);
    if (c_hour) nxt.hour = enc(c_day ? 7'd0 : d_hour + 7'd1, bin_mode);
    if (c_day) begin
      nxt.wday = enc((d_wday >= 7'd7) ? 7'd1 : d_wday + 7'd1, bin_mode);
      nxt.mday = enc(c_mon ? 7'd1 : d_mday + 7'd1, bin_mode);
    end
    if (c_mon)  nxt.mon  = enc(c_year ? 7'd1 : d_mon + 7'd1, bin_mode);
    if (c_year) nxt.year = enc((d_year >= 7'd99) ? 7'd0 : d_year + 7'd1, bin_mode);
  end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PER_HZ = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              pps,
  input  logic              per_tick,
  output logic              irq
);
  localparam logic [2:0] DV_NORMAL = 3'b010;
  localparam logic [3:0] RS_1K     = 4'b0110;
  localparam logic [7:0] B_RESET   = 8'h42;
  localparam logic [7:0] D_VALUE   = 8'h80;

  rtc_time_t  time_q, time_nxt;
  logic [2:0] dv_q;
  logic [3:0] rs_q;
  logic       uip_q;
  logic [7:0] regb_q;
  logic       pf_q;
  logic [7:0] rdata_q;
  logic [7:0] rd_val;
  logic       dv_off, sec_tick, adv;
  logic       sel_a, sel_b, sel_c, time_wr;

  assign sel_a   = addr == ADDR_W'(ADR_A);
  assign sel_b   = addr == ADDR_W'(ADR_B);
  assign sel_c   = addr == ADDR_W'(ADR_C);
  assign time_wr = wr_en && (addr < ADDR_W'(ADR_A));
  assign dv_off  = dv_q[2:1] == 2'b11;
  assign adv     = sec_tick && !regb_q[7];
  assign irq     = pf_q && regb_q[6];
  assign rdata   = rdata_q;

  rtc_secgen #(.PER_HZ(PER_HZ)) u_secgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (!dv_off),
    .pps      (pps),
    .per_tick (per_tick),
    .sec_tick (sec_tick)
  );

  rtc_calendar u_cal (
    .cur      (time_q),
    .bin_mode (regb_q[2]),
    .nxt      (time_nxt)
  );

  always_comb begin
    rd_val = 8'h00;
    case (int'(addr))
      ADR_SEC:  rd_val = time_q.sec;
      ADR_MIN:  rd_val = time_q.min;
      ADR_HOUR: rd_val = time_q.hour;
      ADR_WDAY: rd_val = time_q.wday;
      ADR_MDAY: rd_val = time_q.mday;
      ADR_MON:  rd_val = time_q.mon;
      ADR_YEAR: rd_val = time_q.year;
      ADR_A:    rd_val = {~uip_q, dv_q, rs_q};
      ADR_B:    rd_val = regb_q;
      ADR_C:    rd_val = {irq, pf_q, 6'b0};
      ADR_D:    rd_val = D_VALUE;
      default:  rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q  <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h07,
                   mday: 8'h01, mon: 8'h01, year: 8'h00};
      dv_q    <= DV_NORMAL;
      rs_q    <= RS_1K;
      uip_q   <= 1'b0;
      regb_q  <= B_RESET;
      pf_q    <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      if (time_wr) begin
        case (addr[2:0])
          3'd0:    time_q.sec  <= wdata;
          3'd1:    time_q.min  <= wdata;
          3'd2:    time_q.hour <= wdata;
          3'd3:    time_q.wday <= wdata;
          3'd4:    time_q.mday <= wdata;
          3'd5:    time_q.mon  <= wdata;
          default: time_q.year <= wdata;
        endcase
      end else if (adv) begin
        time_q <= time_nxt;
      end
      if (wr_en && sel_a) begin
        dv_q <= wdata[6:4];
        rs_q <= wdata[3:0];
      end
      if (wr_en && sel_b) regb_q <= wdata;
      if (rd_en && sel_a) uip_q <= ~uip_q;
      if (per_tick)                pf_q <= 1'b1;
      else if (rd_en && sel_c)     pf_q <= 1'b0;
      if (rd_en) rdata_q <= rd_val;
    end
  end

  // R7: stopped divider holds the time unless software writes
  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dv_off && !wr_en) |=> $stable(time_q));

  // R9: set inhibit holds the time unless software writes
  assert_set_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (regb_q[7] && !wr_en) |=> $stable(time_q));

  // R10: every read of A flips the update flag
  assert_uip_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_a) |=> (uip_q != $past(uip_q)));

  // R10: a write to A leaves the update flag alone
  assert_uip_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_a && !rd_en) |=> $stable(uip_q));

  // R11: reading C without a new tick drops the request
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_c && !per_tick) |=> !irq);

  // R11: a periodic tick always leaves the flag set
  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> pf_q);

endmodule

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pps = 1'b0;
  logic       per_tick = 1'b0;
  logic       irq;
  int         n_run = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  rtc_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pps(pps), .per_tick(per_tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_pps();
    @(negedge clk); pps = 1'b1;
    @(negedge clk); pps = 1'b0;
  endtask

  task automatic pulse_per();
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
  endtask

  task automatic t_reset();
    rd_chk("R1 sec", 0, 8'h00); rd_chk("R1 min", 1, 8'h00);
    rd_chk("R1 hour", 2, 8'h00); rd_chk("R1 wday", 3, 8'h07);
    rd_chk("R1 mday", 4, 8'h01); rd_chk("R1 mon", 5, 8'h01);
    rd_chk("R1 year", 6, 8'h00); rd_chk("R1 regB", 8, 8'h42);
    rd_chk("R1 regC", 9, 8'h00); chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_uip();
    rd_chk("R10 first read A", 7, 8'hA6);
    rd_chk("R10 second read A", 7, 8'h26);
    wr(7, 8'hA6);
    rd_chk("R10 write ignored", 7, 8'hA6);
    rd_chk("R10 toggle back", 7, 8'h26);
  endtask

  task automatic t_regs();
    wr(7, 8'h2F);
    rd_chk("R13 regA store", 7, 8'hAF);
    wr(7, 8'h26);
    rd_chk("R13 regA restore", 7, 8'h26);
    wr(8, 8'h6A);
    rd_chk("R13 regB store", 8, 8'h6A);
    wr(8, 8'h42);
    wr(2, 8'h13);
    rd_chk("R2 hour write", 2, 8'h13);
    wr(5, 8'h07);
    rd_chk("R2 month write", 5, 8'h07);
  endtask

  task automatic t_bcd();
    wr(0, 8'h09); pulse_pps();
    rd_chk("R3 bcd 09->10", 0, 8'h10);
    wr(0, 8'h59); wr(1, 8'h14); pulse_pps();
    rd_chk("R3 bcd 59->00", 0, 8'h00);
    rd_chk("R3 bcd min carry", 1, 8'h15);
  endtask

  task automatic t_rollover();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    pulse_pps();
    rd_chk("R5 sec", 0, 8'h00); rd_chk("R5 min", 1, 8'h00);
    rd_chk("R5 hour", 2, 8'h00); rd_chk("R5 wday 7->1", 3, 8'h01);
    rd_chk("R5 mday", 4, 8'h01); rd_chk("R5 mon 12->1", 5, 8'h01);
    rd_chk("R5 year 99->00", 6, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h21);
    pulse_pps();
    rd_chk("R5 april end mday", 4, 8'h01); rd_chk("R5 april end mon", 5, 8'h05);
    rd_chk("R5 wday step", 3, 8'h04);
  endtask

  task automatic t_leap();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    pulse_pps();
    rd_chk("R6 2000 feb 29", 4, 8'h29); rd_chk("R6 2000 still feb", 5, 8'h02);
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h23); pulse_pps();
    rd_chk("R6 2000 mar 1", 4, 8'h01); rd_chk("R6 2000 mar", 5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h01);
    pulse_pps();
    rd_chk("R6 2001 mar 1", 4, 8'h01); rd_chk("R6 2001 mar", 5, 8'h03);
  endtask

  task automatic t_binary();
    wr(8, 8'h46);
    wr(0, 8'd9); pulse_pps();
    rd_chk("R4 bin 9->10", 0, 8'h0A);
    wr(0, 8'd59); wr(1, 8'd5); pulse_pps();
    rd_chk("R4 bin 59->0", 0, 8'h00);
    rd_chk("R4 bin min carry", 1, 8'h06);
    wr(8, 8'h42);
  endtask

  task automatic t_set();
    wr(8, 8'hC2);
    wr(0, 8'h30); pulse_pps();
    rd_chk("R9 held", 0, 8'h30);
    wr(8, 8'h42); pulse_pps();
    rd_chk("R9 released", 0, 8'h31);
  endtask

  task automatic t_divider();
    wr(0, 8'h10);
    wr(7, 8'h66); pulse_pps();
    rd_chk("R7 code 110 stops", 0, 8'h10);
    wr(7, 8'h76); pulse_pps();
    rd_chk("R7 code 111 stops", 0, 8'h10);
    wr(7, 8'h26);
    @(negedge clk); @(negedge clk);
    pulse_pps();
    rd_chk("R8 pps ignored while waiting", 0, 8'h10);
    for (int i = 0; i < 511; i++) pulse_per();
    rd_chk("R8 not yet at half", 0, 8'h10);
    pulse_per();
    rd_chk("R8 first tick at half", 0, 8'h11);
    pulse_pps();
    rd_chk("R8 pps after delay", 0, 8'h12);
  endtask

  task automatic t_periodic();
    logic [7:0] v;
    rd(9, v);
    chk("R11 cleared before test", {7'b0, irq}, 8'h00);
    pulse_per();
    chk("R11 irq raised", {7'b0, irq}, 8'h01);
    rd_chk("R11 read C", 9, 8'hC0);
    chk("R11 irq after read", {7'b0, irq}, 8'h00);
    rd_chk("R11 C cleared", 9, 8'h00);
    wr(8, 8'h02);
    pulse_per();
    chk("R11 irq gated", {7'b0, irq}, 8'h00);
    rd_chk("R11 flag without enable", 9, 8'h40);
    wr(8, 8'h42);
  endtask

  task automatic t_ignored();
    pulse_per();
    wr(9, 8'h00);
    chk("R12 C write ignored irq", {7'b0, irq}, 8'h01);
    rd_chk("R12 C write ignored", 9, 8'hC0);
    wr(10, 8'h00);
    rd_chk("R12 D value", 10, 8'h80);
    wr(12, 8'h55);
    rd_chk("R12 unused addr", 12, 8'h00);
    rd_chk("R12 time intact", 0, 8'h12);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_uip();
        t_regs();
        t_bcd();
        t_rollover();
        t_leap();
        t_binary();
        t_set();
        t_divider();
        t_periodic();
        t_ignored();
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule